// File: doc/BRIEF.md
# Virtual-machine 32/64-bit integer execution unit

This block executes the integer arithmetic, logic, shift, divide and byte-order instructions of a register-based virtual machine. Each request carries a 4-bit operation code, a class bit (64-bit or 32-bit operation), a source-select bit, the destination operand, the source register value and a 32-bit signed immediate. The second operand is the source register value when source-select is 1 and the sign-extended immediate when it is 0. Most operations finish in a single cycle. Unsigned division and remainder use an iterative divider that holds `busy` high while it runs.

Requests enter on a valid/ready handshake and results leave on another. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. A result is offered with `out_valid` and stays unchanged until a rising edge where `out_ready` is high. While a result waits for `out_ready`, `in_ready` is low, so back-pressure from the consumer stalls the producer. The block does not write registers back and does not raise exceptions. It flags the breakpoint encoding on `out_brk` and leaves any other action to its neighbours.

Top module: `vm_int_alu`

## Requirements
- R1: The second operand is `in_src` when `in_use_reg`=1, and otherwise `in_imm` sign-extended to 64 bits. The operation codes are ADD=0, SUB=1, MUL=2, DIV=3, OR=4, AND=5, LSH=6, RSH=7, NEG=8, MOD=9, XOR=A, MOV=B, ARSH=C and END=D. Codes E and F return `in_dst` unmodified.
- R2: With `in_wide`=1, ADD, SUB, MUL, OR, AND, XOR and MOV work on the full 64 bits and wrap modulo 2^64. MOV returns the second operand.
- R3: With `in_wide`=0, every operation other than END and the breakpoint uses only bits 31:0 of both operands, treated as unsigned. Bits 63:32 of the result are zero.
- R4: LSH and RSH are logical shifts and ARSH is arithmetic. The shift amount is the second operand masked to 6 bits in 64-bit mode and to 5 bits in 32-bit mode. A 32-bit ARSH takes its sign from bit 31.
- R5: NEG returns the two's complement of the destination operand and ignores the second operand.
- R6: DIV and MOD are unsigned. `busy` is high and `in_ready` is low while the divider runs. The result appears no more than 66 cycles after the request is accepted.
- R7: DIV by zero returns 0. MOD by zero returns the destination operand, reduced to bits 31:0 in 32-bit mode.
- R8: END ignores `in_wide`. Its width is 16 when `in_imm`=16, 32 when `in_imm`=32, and 64 for any other value. With `in_use_reg`=0 (to little-endian) the result is the low bits of the destination at that width, zero-extended. With `in_use_reg`=1 (to big-endian) the bytes within that width are reversed and the result is zero-extended.
- R9: A request with `in_wide`=0, `in_use_reg`=1 and op NEG is a breakpoint. It sets `out_brk`=1 and returns `in_dst` unchanged in all 64 bits. Every other request gives `out_brk`=0.
- R10: A request is taken when `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_result` and `out_brk` hold and `in_ready` is low.
- R11: After reset `out_valid`=0, `busy`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_wide | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| in_use_reg | input | 1 | Source select; for END, the conversion direction |
| in_dst | input | 64 | Destination operand |
| in_src | input | 64 | Source register operand |
| in_imm | input | 32 | Signed immediate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Result |
| out_brk | output | 1 | Request was the breakpoint encoding |
| busy | output | 1 | Iterative divider running |

## Verification
The bench sweeps every operation code in both classes and with both operand sources, over patterns that include shift amounts above the masks, negative immediates and zero divisors. A design that forgets to mask the shift amount shifts everything out. A design that does not clear the upper half in 32-bit mode leaks carries and sign bits into bits 63:32. A design that lets the raw divider output through returns all ones for a divide by zero. END runs at each width and in both directions. A swap taken from the wrong end of the word, or missing zero-extension, shows up as garbage above the selected width. The bench also holds `out_ready` low and checks that the result stays the same, and it checks that the breakpoint encoding passes the destination through instead of negating it.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_LSH  = 4'h6,
    OP_RSH  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'hA,
    OP_MOV  = 4'hB,
    OP_ARSH = 4'hC,
    OP_END  = 4'hD,
    OP_RSVE = 4'hE,
    OP_RSVF = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    BSW_16 = 2'd0,
    BSW_32 = 2'd1,
    BSW_64 = 2'd2
  } bsw_width_e;

  function automatic bsw_width_e width_from_imm(input logic [31:0] imm);
    if (imm == 32'd16)      return BSW_16;
    else if (imm == 32'd32) return BSW_32;
    else                    return BSW_64;
  endfunction

endpackage

// File: rtl/vm_alu_bswap.sv
module vm_alu_bswap
  import vm_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val,
  input  logic            to_big,
  input  bsw_width_e      width,
  output logic [XLEN-1:0] res
);
  localparam int NBYTES = XLEN / 8;
  localparam int NW     = 3;

  logic [NW-1:0][XLEN-1:0] swp;
  logic [NW-1:0][XLEN-1:0] trn;

  for (genvar k = 0; k < NW; k++) begin : g_w
    localparam int NB = 2 << k;
    logic [XLEN-1:0] sw_k;
    for (genvar b = 0; b < NB; b++) begin : g_b
      assign sw_k[8*b +: 8] = val[8*(NB-1-b) +: 8];
    end
    if (NB < NBYTES) begin : g_pad
      assign sw_k[XLEN-1:8*NB] = '0;
      assign trn[k] = {{(XLEN-8*NB){1'b0}}, val[8*NB-1:0]};
    end else begin : g_full
      assign trn[k] = val;
    end
    assign swp[k] = sw_k;
  end

  always_comb begin
    res = '0;
    for (int k = 0; k < NW; k++) begin
      if (width == bsw_width_e'(k)) res = to_big ? swp[k] : trn[k];
    end
  end

endmodule

// File: rtl/vm_alu_divider.sv
module vm_alu_divider #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic            done,
  output logic [XLEN-1:0] quotient,
  output logic [XLEN-1:0] remainder
);
  localparam int CW = $clog2(XLEN + 1);

  logic [XLEN-1:0] rem_q, quo_q, dsr_q;
  logic [CW-1:0]   cnt_q;
  logic            run_q, done_q;
  logic [XLEN:0]   shifted, diff;
  logic            fits;

  assign shifted = {rem_q, quo_q[XLEN-1]};
  assign diff    = shifted - {1'b0, dsr_q};
  assign fits    = ~diff[XLEN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(XLEN);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff[XLEN-1:0] : shifted[XLEN-1:0];
        quo_q <= {quo_q[XLEN-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;

endmodule

// File: rtl/vm_alu_exec.sv
module vm_alu_exec
  import vm_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  alu_op_e         op,
  input  logic            wide,
  input  logic            use_reg,
  input  logic [XLEN-1:0] dst,
  input  logic [XLEN-1:0] src,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] result,
  output logic            brk,
  output logic            need_div,
  output logic            is_mod,
  output logic            div_zero,
  output logic [XLEN-1:0] div_a,
  output logic [XLEN-1:0] div_b
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  logic [XLEN-1:0]        opb_full, a, b, raw, bsw;
  logic [SHW-1:0]         shamt;
  logic signed [XLEN-1:0] sa, arsh_val;

  assign opb_full = use_reg ? src : {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign a        = wide ? dst      : {{HALF{1'b0}}, dst[HALF-1:0]};
  assign b        = wide ? opb_full : {{HALF{1'b0}}, opb_full[HALF-1:0]};
  assign shamt    = wide ? b[SHW-1:0] : {1'b0, b[SHW-2:0]};
  assign sa       = wide ? $signed(dst) : $signed({{HALF{dst[HALF-1]}}, dst[HALF-1:0]});
  assign arsh_val = sa >>> shamt;

  vm_alu_bswap #(.XLEN(XLEN)) u_bswap (
    .val    (dst),
    .to_big (use_reg),
    .width  (width_from_imm(imm)),
    .res    (bsw)
  );

  always_comb begin
    raw = a;
    case (op)
      OP_ADD:  raw = a + b;
      OP_SUB:  raw = a - b;
      OP_MUL:  raw = a * b;
      OP_OR:   raw = a | b;
      OP_AND:  raw = a & b;
      OP_XOR:  raw = a ^ b;
      OP_LSH:  raw = a << shamt;
      OP_RSH:  raw = a >> shamt;
      OP_ARSH: raw = arsh_val;
      OP_NEG:  raw = -a;
      OP_MOV:  raw = b;
      default: raw = a;
    endcase
  end

  assign brk      = !wide && use_reg && (op == OP_NEG);
  assign need_div = (op == OP_DIV) || (op == OP_MOD);
  assign is_mod   = (op == OP_MOD);
  assign div_zero = (b == '0);
  assign div_a    = a;
  assign div_b    = b;

  always_comb begin
    if (brk || op == OP_RSVE || op == OP_RSVF) result = dst;
    else if (op == OP_END)                     result = bsw;
    else if (wide)                             result = raw;
    else                                       result = {{HALF{1'b0}}, raw[HALF-1:0]};
  end

endmodule

// File: rtl/vm_int_alu.sv
module vm_int_alu
  import vm_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_op,
  input  logic            in_wide,
  input  logic            in_use_reg,
  input  logic [XLEN-1:0] in_dst,
  input  logic [XLEN-1:0] in_src,
  input  logic [IMMW-1:0] in_imm,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_brk,
  output logic            busy
);
  typedef enum logic [1:0] {S_IDLE, S_DIV, S_OUT} state_e;

  state_e          state_q;
  logic [XLEN-1:0] res_q, pend_a_q;
  logic            brk_q, pend_mod_q, pend_zero_q;

  logic [XLEN-1:0] ex_res, ex_da, ex_db, quo, rem;
  logic            ex_brk, ex_div, ex_mod, ex_zero, div_done, accept;

  vm_alu_exec #(.XLEN(XLEN), .IMMW(IMMW)) u_exec (
    .op       (alu_op_e'(in_op)),
    .wide     (in_wide),
    .use_reg  (in_use_reg),
    .dst      (in_dst),
    .src      (in_src),
    .imm      (in_imm),
    .result   (ex_res),
    .brk      (ex_brk),
    .need_div (ex_div),
    .is_mod   (ex_mod),
    .div_zero (ex_zero),
    .div_a    (ex_da),
    .div_b    (ex_db)
  );

  assign in_ready = (state_q == S_IDLE) || (state_q == S_OUT && out_ready);
  assign accept   = in_valid && in_ready;

  vm_alu_divider #(.XLEN(XLEN)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept && ex_div),
    .dividend  (ex_da),
    .divisor   (ex_db),
    .done      (div_done),
    .quotient  (quo),
    .remainder (rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      res_q       <= '0;
      brk_q       <= 1'b0;
      pend_a_q    <= '0;
      pend_mod_q  <= 1'b0;
      pend_zero_q <= 1'b0;
    end else if (accept) begin
      if (ex_div) begin
        state_q     <= S_DIV;
        pend_a_q    <= ex_da;
        pend_mod_q  <= ex_mod;
        pend_zero_q <= ex_zero;
      end else begin
        state_q <= S_OUT;
        res_q   <= ex_res;
        brk_q   <= ex_brk;
      end
    end else begin
      case (state_q)
        S_DIV: if (div_done) begin
          state_q <= S_OUT;
          brk_q   <= 1'b0;
          if (pend_mod_q)       res_q <= pend_zero_q ? pend_a_q : rem;
          else if (pend_zero_q) res_q <= '0;
          else                  res_q <= quo;
        end
        S_OUT: if (out_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign out_valid  = (state_q == S_OUT);
  assign out_result = res_q;
  assign out_brk    = brk_q;
  assign busy       = (state_q == S_DIV);

endmodule

// File: rtl/vm_int_alu_chk.sv
module vm_int_alu_chk #(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [3:0]      in_op,
  input logic            in_wide,
  input logic            in_use_reg,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic            out_brk,
  input logic            busy
);
  localparam int HALF = XLEN / 2;
  localparam int LW   = $clog2(XLEN + 4);

  logic [3:0]    rec_op;
  logic          rec_wide, rec_ur;
  logic [LW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_op   <= 4'h0;
      rec_wide <= 1'b1;
      rec_ur   <= 1'b0;
      lat_cnt  <= '0;
    end else begin
      if (in_valid && in_ready) begin
        rec_op   <= in_op;
        rec_wide <= in_wide;
        rec_ur   <= in_use_reg;
      end
      lat_cnt <= busy ? lat_cnt + 1'b1 : '0;
    end
  end

  assert_reset_idle_R11: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && !busy && in_ready));

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_brk)));

  assert_stall_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!in_ready && !out_valid));

  assert_div_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lat_cnt <= LW'(XLEN)));

  assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !rec_wide && rec_op < 4'hD && !(rec_ur && rec_op == 4'h8))
      |-> (out_result[XLEN-1:HALF] == '0));

  assert_brk_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_brk) |-> (!rec_wide && rec_ur && rec_op == 4'h8));

  assert_brk_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !rec_wide && rec_ur && rec_op == 4'h8) |-> out_brk);

endmodule

bind vm_int_alu vm_int_alu_chk #(.XLEN(XLEN), .IMMW(IMMW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_wide    (in_wide),
  .in_use_reg (in_use_reg),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_brk    (out_brk),
  .busy       (busy)
);

// File: tb/vm_int_alu_bench.sv
module vm_int_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = 4'h0;
  logic        in_wide = 1'b1;
  logic        in_use_reg = 1'b0;
  logic [63:0] in_dst = '0;
  logic [63:0] in_src = '0;
  logic [31:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_brk;
  logic        busy;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vm_int_alu u_vm_int_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wide(in_wide), .in_use_reg(in_use_reg),
    .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_brk(out_brk), .busy(busy)
  );

  function automatic logic [63:0] model(input logic [3:0] op, input bit wide, input bit ur,
                                        input logic [63:0] d, input logic [63:0] s,
                                        input logic [31:0] im);
    logic [63:0] bop, a, bb, r;
    int sh, nb;
    bop = ur ? s : {{32{im[31]}}, im};
    a   = wide ? d : {32'h0, d[31:0]};
    bb  = wide ? bop : {32'h0, bop[31:0]};
    sh  = wide ? int'(bb % 64) : int'(bb % 32);
    if (!wide && ur && op == 4'h8) return d;
    if (op == 4'hE || op == 4'hF) return d;
    if (op == 4'hD) begin
      nb = (im == 32'd16) ? 2 : (im == 32'd32) ? 4 : 8;
      r = '0;
      for (int i = 0; i < nb; i++)
        r[8*i +: 8] = ur ? d[8*(nb-1-i) +: 8] : d[8*i +: 8];
      return r;
    end
    case (op)
      4'h0: r = a + bb;
      4'h1: r = a - bb;
      4'h2: r = a * bb;
      4'h3: r = (bb == 0) ? 64'h0 : a / bb;
      4'h4: r = a | bb;
      4'h5: r = a & bb;
      4'h6: r = a << sh;
      4'h7: r = a >> sh;
      4'h8: r = 64'h0 - a;
      4'h9: r = (bb == 0) ? a : a % bb;
      4'hA: r = a ^ bb;
      4'hB: r = bb;
      default: begin
        if (wide) r = $unsigned($signed(a) >>> sh);
        else      r = {32'h0, 32'($unsigned($signed(a[31:0]) >>> sh))};
      end
    endcase
    if (!wide) r = {32'h0, r[31:0]};
    return r;
  endfunction

  function automatic string req_of(input logic [3:0] op, input bit wide, input bit ur,
                                   input logic [63:0] s, input logic [31:0] im);
    logic [63:0] bop;
    bop = ur ? s : {{32{im[31]}}, im};
    if (!wide) bop = {32'h0, bop[31:0]};
    if (!wide && ur && op == 4'h8) return "R9";
    if (op == 4'hD) return "R8";
    if (op == 4'hE || op == 4'hF) return "R1";
    if (op == 4'h8) return "R5";
    if (op == 4'h6 || op == 4'h7 || op == 4'hC) return "R4";
    if (op == 4'h3 || op == 4'h9) return (bop == 0) ? "R7" : "R6";
    if (!wide) return "R3";
    return "R2";
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input bit wide, input bit ur,
                       input logic [63:0] d, input logic [63:0] s, input logic [31:0] im,
                       input string req);
    int lat;
    @(negedge clk);
    in_op = op; in_wide = wide; in_use_reg = ur;
    in_dst = d; in_src = s; in_imm = im; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(req, $sformatf("op=%h wide=%0d reg=%0d result", op, wide, ur),
          out_result, model(op, wide, ur, d, s, im));
    check(req, "breakpoint flag", {63'h0, out_brk},
          {63'h0, (!wide && ur && op == 4'h8)});
    if (op == 4'h3 || op == 4'h9)
      check("R6", "divide latency within 66", {63'h0, lat <= 66}, 64'h1);
  endtask

  logic [63:0] dpat [8];
  logic [63:0] spat [8];
  logic [31:0] ipat [8];

  initial begin
    dpat = '{64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
             64'h0123_4567_89AB_CDEF, 64'h0000_0000_8000_0001,
             64'hFEDC_BA98_7654_3210, 64'h7FFF_FFFF_0000_0005};
    spat = '{64'h0, 64'd63, 64'd33, 64'hFFFF_FFFF_FFFF_FFF1, 64'd65,
             64'h0000_0001_0000_0000, 64'd7, 64'h1234_5678_9ABC_DEF1};
    ipat = '{32'h0, 32'hFFFF_FFFF, 32'd16, 32'd32, 32'd64, 32'd7,
             32'h8000_0000, 32'd3};

    repeat (3) @(negedge clk);
    check("R11", "out_valid after reset", {63'h0, out_valid}, 64'h0);
    check("R11", "busy after reset", {63'h0, busy}, 64'h0);
    check("R11", "in_ready after reset", {63'h0, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "in_ready after reset release", {63'h0, in_ready}, 64'h1);

    // R1: the immediate -2 is sign-extended before a 64-bit ADD
    apply(4'h0, 1'b1, 1'b0, 64'd10, 64'hDEAD, 32'hFFFF_FFFE, "R1");
    // R5: NEG ignores the register operand
    apply(4'h8, 1'b1, 1'b1, 64'd5, 64'h1234, 32'd9, "R5");
    // R8: each END width in both directions
    for (int w = 0; w < 4; w++) begin
      logic [31:0] wi;
      wi = (w == 0) ? 32'd16 : (w == 1) ? 32'd32 : (w == 2) ? 32'd64 : 32'd5;
      apply(4'hD, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'h0, wi, "R8");
      apply(4'hD, 1'b1, 1'b1, 64'h1122_3344_5566_7788, 64'h0, wi, "R8");
    end
    // R7: explicit zero divisors in both classes
    apply(4'h3, 1'b1, 1'b1, 64'hABCD, 64'h0, 32'h0, "R7");
    apply(4'h9, 1'b0, 1'b0, 64'hFFFF_0000_0000_0009, 64'h0, 32'h0, "R7");
    // R9: the breakpoint encoding returns the destination unchanged
    apply(4'h8, 1'b0, 1'b1, 64'hCAFE_0000_0000_0001, 64'h0, 32'h0, "R9");

    // sweep: every code, class and operand source
    for (int op = 0; op < 16; op++)
      for (int wd = 0; wd < 2; wd++)
        for (int ur = 0; ur < 2; ur++)
          for (int i = 0; i < 8; i++)
            apply(4'(op), wd[0], ur[0], dpat[i], spat[(i+3)%8], ipat[(i+5)%8],
                  req_of(4'(op), wd[0], ur[0], spat[(i+3)%8], ipat[(i+5)%8]));

    // R6: busy raised and input stalled during a division
    @(negedge clk);
    in_op = 4'h3; in_wide = 1'b1; in_use_reg = 1'b1;
    in_dst = 64'd1000; in_src = 64'd7; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6", "busy during divide", {63'h0, busy}, 64'h1);
    check("R6", "in_ready low during divide", {63'h0, in_ready}, 64'h0);
    while (!out_valid) @(negedge clk);
    check("R6", "quotient 1000/7", out_result, 64'd142);

    // R10: a result is held under back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'h0; in_wide = 1'b1; in_use_reg = 1'b1;
    in_dst = 64'd40; in_src = 64'd2; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_dst = 64'd99;
    repeat (4) @(negedge clk);
    check("R10", "valid held under back-pressure", {63'h0, out_valid}, 64'h1);
    check("R10", "result held under back-pressure", out_result, 64'd42);
    check("R10", "in_ready low under back-pressure", {63'h0, in_ready}, 64'h0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R10", "next request accepted after drain", out_result, 64'd101);
    in_valid = 1'b0;
    @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule